// File: doc/BRIEF.md
# Shift and Rotate Unit with Condition Flags

This block shifts or rotates an operand by a count taken from a register and derives five condition flags from the result: carry, extend, overflow, negative and zero. It handles byte, word and longword operand sizes. The operations are arithmetic and logical shifts in either direction, plain rotates, and rotates that pass through the extend bit. The datapath is combinational. One output register stage holds the result and the flags, so a pipelined execute stage can use the unit.

Control is a two-state machine. `ST_EMPTY` means no fresh result is held. `ST_FULL` means the output register was loaded on the last clock edge. The *accept* transition goes from either state to `ST_FULL` when `in_valid` is high. The *drain* transition goes from either state to `ST_EMPTY` when `in_valid` is low. `out_valid` is high only in `ST_FULL`. The output registers load only on accept and otherwise keep their value.

Operation code on `op_sel`:
- 0: arithmetic shift left
- 1: arithmetic shift right
- 2: logical shift left
- 3: logical shift right
- 4: rotate left
- 5: rotate right
- 6: rotate left through extend
- 7: rotate right through extend

Size code on `size_sel`:
- 0: 8 bits
- 1: 16 bits
- 2: 32 bits
- 3: also 32 bits

Below, W is the selected width and n is the effective count.

Top module: `shrot_unit`

## Requirements
- R1: While `rst_n` is low, and afterwards until the first accepted operation, `out_valid`, `result` and all five flags are 0.
- R2: An operation presented with `in_valid` high appears on the outputs after the next rising clock edge, with `out_valid` high. In a cycle with `in_valid` low, `out_valid` falls and `result` and the flags hold their values. Operation codes: 0 arithmetic left, 1 arithmetic right, 2 logical left, 3 logical right, 4 rotate left, 5 rotate right, 6 rotate left through extend, 7 rotate right through extend.
- R3: Only `shift_cnt[5:0]` is used, so the effective count n is the supplied count modulo 64. Bits 7:6 have no effect.
- R4: When n is 0, every shift and plain rotate returns the operand unchanged, clears carry and overflow, and leaves extend equal to `x_in`.
- R5: For n in 1..W, a left shift sets carry and extend to operand bit W-n, the last bit shifted out. For n > W both are 0. For n >= W the sized result is 0.
- R6: An arithmetic left shift sets overflow when the sign bit changes at any step. For n < W this means the top n+1 bits of the operand are not all equal. For n >= W it means the operand is nonzero.
- R7: Logical shifts in both directions and arithmetic right shifts always clear overflow.
- R8: A right shift fills with the sign bit (arithmetic) or with 0 (logical). For n in 1..W, carry and extend take operand bit n-1. For n > W they are 0. For n >= W the sized result is all fill bits.
- R9: Plain rotates use n mod W. Carry is the new bit 0 after a left rotate and the new bit W-1 after a right rotate, and is 0 when n is 0. Extend equals `x_in` and overflow is 0.
- R10: Rotates through extend move the (W+1)-bit ring made of extend above the operand by n mod (W+1) places. Carry and extend both become the last bit rotated out. When n mod (W+1) is 0, carry equals `x_in` and extend is unchanged. Overflow is 0.
- R11: Negative is bit W-1 of the sized result. Zero is set exactly when all W result bits are 0.
- R12: Size codes are 0 for 8 bits, 1 for 16 bits, and 2 or 3 for 32 bits. Result bits above W equal the operand bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present this cycle |
| op_sel | input | 3 | Operation code |
| size_sel | input | 2 | Operand size code |
| shift_cnt | input | 8 | Count; low six bits used |
| operand | input | 32 | Value to shift or rotate |
| x_in | input | 1 | Incoming extend bit |
| out_valid | output | 1 | Result register loaded on the last edge |
| result | output | 32 | Shifted value, upper bits passed through |
| c_out | output | 1 | Carry flag |
| x_out | output | 1 | Extend flag |
| v_out | output | 1 | Overflow flag |
| n_out | output | 1 | Negative flag |
| z_out | output | 1 | Zero flag |

## Verification
The bench targets counts equal to W, W+1 and 63:
- A design that clears carry at n = W instead of only above W fails on the single-bit case of the left and right shifts.
- A design that returns the sign bit at large counts on an arithmetic right shift fails on the carry.

On the rotate-through-extend side, counts that are multiples of W+1 catch a unit that reduces the count by W, or that clears carry instead of copying the extend bit. Three further cases target:
- arithmetic-left operands whose top bits change only deep in the field, which catch an overflow computed from the final sign alone;
- counts with bits 7:6 set, which catch a design that uses the whole count byte;
- byte and word operations with random upper bits, which catch clobbered pass-through bits and flags taken from bit 31.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    typedef enum logic [2:0] {
        OP_ASL  = 3'd0,
        OP_ASR  = 3'd1,
        OP_LSL  = 3'd2,
        OP_LSR  = 3'd3,
        OP_ROL  = 3'd4,
        OP_ROR  = 3'd5,
        OP_ROXL = 3'd6,
        OP_ROXR = 3'd7
    } shrot_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_ALT  = 2'd3
    } shrot_size_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } shrot_state_e;

    typedef struct packed {
        logic c;
        logic x;
        logic v;
        logic n;
        logic z;
    } shrot_flags_t;

endpackage

// File: rtl/shrot_lane.sv
module shrot_lane
    import shrot_pkg::*;
#(
    parameter int W     = 8,
    parameter int CNT_W = 6
) (
    input  shrot_op_e    op,
    input  logic [CNT_W-1:0] cnt,
    input  logic [W-1:0] opnd,
    input  logic         xin,
    output logic [W-1:0] res,
    output shrot_flags_t flg
);
    localparam int RB  = $clog2(W);
    localparam int PAD = 1 << CNT_W;
    localparam logic [CNT_W:0] W_C  = (CNT_W+1)'(W);
    localparam logic [CNT_W-1:0] RING = CNT_W'(W + 1);

    logic [CNT_W:0]      cnt_x;
    logic [W+PAD-1:0]    lsh;
    logic [W+PAD-1:0]    rsh;
    logic [W:0]          rcar;
    logic [2*W-1:0]      rot_l;
    logic [2*W-1:0]      rot_r;
    logic [RB-1:0]       rmod;
    logic [CNT_W-1:0]    xmod;
    logic [2*W+1:0]      xr_l;
    logic [2*W+1:0]      xr_r;
    logic [W-1:0]        top_mask;
    logic                fill;

    always_comb begin
        cnt_x    = {1'b0, cnt};
        fill     = (op == OP_ASR) ? opnd[W-1] : 1'b0;
        lsh      = {{PAD{1'b0}}, opnd} << cnt;
        rsh      = {{PAD{fill}}, opnd} >> cnt;
        rcar     = {opnd, 1'b0} >> cnt;
        rmod     = cnt[RB-1:0];
        rot_l    = {opnd, opnd} << rmod;
        rot_r    = {opnd, opnd} >> rmod;
        xmod     = cnt % RING;
        xr_l     = {xin, opnd, xin, opnd} << xmod;
        xr_r     = {xin, opnd, xin, opnd} >> xmod;
        top_mask = ~({W{1'b1}} >> (cnt_x + (CNT_W+1)'(1)));

        res   = opnd;
        flg.c = 1'b0;
        flg.x = xin;
        flg.v = 1'b0;

        unique case (op)
            OP_ASL, OP_LSL: begin
                res = lsh[W-1:0];
                if (cnt != '0) begin
                    flg.c = (cnt_x > W_C) ? 1'b0 : lsh[W];
                    flg.x = flg.c;
                end
                if (op == OP_ASL && cnt != '0) begin
                    if (cnt_x >= W_C) flg.v = |opnd;
                    else flg.v = ((opnd & top_mask) != '0) && ((opnd & top_mask) != top_mask);
                end
            end
            OP_ASR, OP_LSR: begin
                res = rsh[W-1:0];
                if (cnt != '0) begin
                    flg.c = (cnt_x > W_C) ? 1'b0 : rcar[0];
                    flg.x = flg.c;
                end
            end
            OP_ROL: begin
                res = rot_l[2*W-1:W];
                if (cnt != '0) flg.c = res[0];
            end
            OP_ROR: begin
                res = rot_r[W-1:0];
                if (cnt != '0) flg.c = res[W-1];
            end
            OP_ROXL: begin
                res   = xr_l[2*W:W+1];
                flg.x = xr_l[2*W+1];
                flg.c = flg.x;
            end
            OP_ROXR: begin
                res   = xr_r[W-1:0];
                flg.x = xr_r[W];
                flg.c = flg.x;
            end
        endcase

        flg.n = res[W-1];
        flg.z = (res == '0);
    end

endmodule

// File: rtl/shrot_select.sv
module shrot_select
    import shrot_pkg::*;
#(
    parameter int NUM_SIZES = 3,
    parameter int BASE_W    = 8,
    parameter int DATA_W    = BASE_W << (NUM_SIZES - 1)
) (
    input  shrot_size_e  size,
    input  logic [DATA_W-1:0] opnd,
    input  logic [DATA_W-1:0] lane_res [NUM_SIZES],
    input  shrot_flags_t lane_flg [NUM_SIZES],
    output logic [DATA_W-1:0] res,
    output shrot_flags_t flg
);
    localparam int IDX_W = $clog2(NUM_SIZES);

    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] keep_mask [NUM_SIZES];

    for (genvar gi = 0; gi < NUM_SIZES; gi++) begin : g_mask
        localparam int LW = BASE_W << gi;
        assign keep_mask[gi] = ~(DATA_W'({LW{1'b1}}));
    end

    always_comb begin
        if (int'(size) >= NUM_SIZES - 1) idx = IDX_W'(NUM_SIZES - 1);
        else idx = IDX_W'(size);
        res = (opnd & keep_mask[idx]) | lane_res[idx];
        flg = lane_flg[idx];
    end

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int NUM_SIZES = 3,
    parameter int BASE_W    = 8,
    parameter int CNT_IN_W  = 8,
    parameter int CNT_W     = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [2:0]          op_sel,
    input  logic [1:0]          size_sel,
    input  logic [CNT_IN_W-1:0] shift_cnt,
    input  logic [31:0]         operand,
    input  logic                x_in,
    output logic                out_valid,
    output logic [31:0]         result,
    output logic                c_out,
    output logic                x_out,
    output logic                v_out,
    output logic                n_out,
    output logic                z_out
);
    localparam int DATA_W = BASE_W << (NUM_SIZES - 1);

    shrot_op_e    op;
    logic [CNT_W-1:0] cnt;
    logic [DATA_W-1:0] lane_res [NUM_SIZES];
    shrot_flags_t lane_flg [NUM_SIZES];
    logic [DATA_W-1:0] sel_res;
    shrot_flags_t sel_flg;
    shrot_state_e state_q, state_d;
    logic [DATA_W-1:0] res_q;
    shrot_flags_t flg_q;

    assign op  = shrot_op_e'(op_sel);
    assign cnt = shift_cnt[CNT_W-1:0];

    for (genvar gi = 0; gi < NUM_SIZES; gi++) begin : g_lane
        localparam int LW = BASE_W << gi;
        logic [LW-1:0] lr;
        shrot_lane #(.W(LW), .CNT_W(CNT_W)) lane_i (
            .op   (op),
            .cnt  (cnt),
            .opnd (operand[LW-1:0]),
            .xin  (x_in),
            .res  (lr),
            .flg  (lane_flg[gi])
        );
        assign lane_res[gi] = DATA_W'(lr);
    end

    shrot_select #(.NUM_SIZES(NUM_SIZES), .BASE_W(BASE_W), .DATA_W(DATA_W)) sel_i (
        .size     (shrot_size_e'(size_sel)),
        .opnd     (operand),
        .lane_res (lane_res),
        .lane_flg (lane_flg),
        .res      (sel_res),
        .flg      (sel_flg)
    );

    always_comb begin
        unique case (state_q)
            ST_EMPTY: state_d = in_valid ? ST_FULL : ST_EMPTY;
            ST_FULL:  state_d = in_valid ? ST_FULL : ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            res_q   <= '0;
            flg_q   <= '0;
        end else begin
            state_q <= state_d;
            if (in_valid) begin
                res_q <= sel_res;
                flg_q <= sel_flg;
            end
        end
    end

    always_comb begin
        out_valid = (state_q == ST_FULL);
        result    = res_q;
        c_out     = flg_q.c;
        x_out     = flg_q.x;
        v_out     = flg_q.v;
        n_out     = flg_q.n;
        z_out     = flg_q.z;
    end

    // R2: out_valid follows in_valid by one edge
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R2: outputs hold when nothing is accepted
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(in_valid) && $past(rst_n)) |-> ($stable(result) && $stable(c_out) && $stable(x_out)));

    // R7: logical shifts and right shifts never flag overflow
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ($past(op_sel) inside {3'd1, 3'd2, 3'd3})) |-> !v_out);

    // R9: plain rotates keep extend and clear overflow
    a_r9_rot_keep_x: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ($past(op_sel) inside {3'd4, 3'd5})) |-> (x_out == $past(x_in) && !v_out));

    // R4: zero count on shifts leaves extend and clears carry
    a_r4_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(shift_cnt[CNT_W-1:0]) == '0 && $past(op_sel) < 3'd6)
        |-> (x_out == $past(x_in) && !c_out && !v_out && result == $past(operand)));

    // R12: byte operations pass the upper bits through
    a_r12_upper_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(size_sel) == 2'd0) |-> (result[DATA_W-1:BASE_W] == $past(operand[DATA_W-1:BASE_W])));

    // R10: extend rotates leave carry equal to extend
    a_r10_carry_eq_x: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(op_sel) >= 3'd6) |-> (c_out == x_out && !v_out));

endmodule

// File: tb/shrot_unit_tb.sv
module shrot_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [1:0]  size_sel = '0;
    logic [7:0]  shift_cnt = '0;
    logic [31:0] operand = '0;
    logic        x_in = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic        c_out, x_out, v_out, n_out, z_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    shrot_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .size_sel(size_sel), .shift_cnt(shift_cnt), .operand(operand), .x_in(x_in),
        .out_valid(out_valid), .result(result), .c_out(c_out), .x_out(x_out),
        .v_out(v_out), .n_out(n_out), .z_out(z_out)
    );

    // Reference: step the operand one bit at a time
    function automatic logic [36:0] model(input logic [2:0] op, input logic [1:0] sz,
                                          input logic [7:0] cnt8, input logic [31:0] a,
                                          input logic xi);
        int w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        int n = int'(cnt8[5:0]);
        logic [31:0] mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        logic [31:0] v = a & mask;
        logic sgn = a[w-1];
        logic c = 1'b0, xo = xi, ov = 1'b0, t;
        case (op)
            3'd0, 3'd2: begin
                for (int i = 0; i < n; i++) begin
                    c = v[w-1];
                    v = (v << 1) & mask;
                    if (op == 3'd0 && v[w-1] != sgn) ov = 1'b1;
                end
                if (n > 0) xo = c;
            end
            3'd1, 3'd3: begin
                for (int i = 0; i < n; i++) begin
                    c = v[0];
                    v = ((v >> 1) | (((op == 3'd1) ? 32'(sgn) : 32'd0) << (w - 1))) & mask;
                end
                if (n > w) c = 1'b0;
                if (n > 0) xo = c;
            end
            3'd4: begin
                for (int i = 0; i < n; i++) v = ((v << 1) | 32'(v[w-1])) & mask;
                if (n > 0) c = v[0];
            end
            3'd5: begin
                for (int i = 0; i < n; i++) v = (v >> 1) | (32'(v[0]) << (w - 1));
                if (n > 0) c = v[w-1];
            end
            3'd6: begin
                for (int i = 0; i < n; i++) begin
                    t = v[w-1]; v = ((v << 1) | 32'(xo)) & mask; xo = t;
                end
                c = xo;
            end
            default: begin
                for (int i = 0; i < n; i++) begin
                    t = v[0]; v = (v >> 1) | (32'(xo) << (w - 1)); xo = t;
                end
                c = xo;
            end
        endcase
        return {(a & ~mask) | v, c, xo, ov, v[w-1], (v == 32'd0)};
    endfunction

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0: return "R6";
            3'd1: return "R8";
            3'd2: return "R5";
            3'd3: return "R7";
            3'd4, 3'd5: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic [36:0] got, input logic [36:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got res=%h cxvnz=%b expected res=%h cxvnz=%b",
                     tag, got[36:5], got[4:0], exp[36:5], exp[4:0]);
        end
    endtask

    task automatic run(input logic [2:0] op, input logic [1:0] sz, input logic [7:0] cnt,
                       input logic [31:0] a, input logic xi, input string tag);
        @(negedge clk);
        op_sel = op; size_sel = sz; shift_cnt = cnt; operand = a; x_in = xi; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, {result, c_out, x_out, v_out, n_out, z_out}, model(op, sz, cnt, a, xi));
        checks++;
        if (out_valid !== 1'b1) begin
            fails++;
            $display("FAIL R2: out_valid got %b expected 1", out_valid);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [36:0] held;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {result, c_out, x_out, v_out, n_out, z_out}, 37'd0);
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1: out_valid got %b expected 0", out_valid);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {result, c_out, x_out, v_out, n_out, z_out}, 37'd0);

        // directed corner cases
        run(3'd2, 2'd0, 8'd8,  32'hAAAA_AA81, 1'b0, "R5");
        run(3'd2, 2'd0, 8'd9,  32'h0000_00FF, 1'b1, "R5");
        run(3'd0, 2'd1, 8'd3,  32'h1FFF_1FFF, 1'b0, "R6");
        run(3'd0, 2'd1, 8'd3,  32'h0000_E000, 1'b0, "R6");
        run(3'd0, 2'd0, 8'd8,  32'h0000_0001, 1'b0, "R6");
        run(3'd0, 2'd2, 8'd40, 32'h0000_0000, 1'b1, "R6");
        run(3'd1, 2'd0, 8'd8,  32'h0000_0080, 1'b0, "R8");
        run(3'd1, 2'd0, 8'd9,  32'h0000_0080, 1'b1, "R8");
        run(3'd3, 2'd2, 8'd32, 32'h8000_0000, 1'b0, "R8");
        run(3'd3, 2'd1, 8'd5,  32'h1234_FFFF, 1'b0, "R7");
        run(3'd4, 2'd0, 8'd8,  32'h0000_0081, 1'b1, "R9");
        run(3'd5, 2'd1, 8'd20, 32'h0000_0001, 1'b0, "R9");
        run(3'd6, 2'd0, 8'd9,  32'h0000_0055, 1'b1, "R10");
        run(3'd7, 2'd1, 8'd34, 32'h0000_8001, 1'b0, "R10");
        run(3'd6, 2'd2, 8'd33, 32'h8000_0001, 1'b1, "R10");
        run(3'd7, 2'd0, 8'd1,  32'h0000_0001, 1'b0, "R10");
        run(3'd6, 2'd0, 8'd0,  32'h0000_0033, 1'b1, "R10");
        run(3'd0, 2'd2, 8'd0,  32'hDEAD_BEEF, 1'b1, "R4");
        run(3'd4, 2'd1, 8'd0,  32'h0000_8000, 1'b1, "R4");
        run(3'd2, 2'd0, 8'hC3, 32'h0000_0011, 1'b0, "R3");
        run(3'd5, 2'd2, 8'h40, 32'h0000_0003, 1'b0, "R3");
        run(3'd3, 2'd0, 8'd1,  32'hFFFF_FF01, 1'b0, "R11");
        run(3'd2, 2'd1, 8'd1,  32'h0000_4000, 1'b0, "R11");
        run(3'd1, 2'd3, 8'd4,  32'h8765_4321, 1'b0, "R12");
        run(3'd4, 2'd0, 8'd3,  32'hCAFE_F00D, 1'b0, "R12");

        // R2: hold with in_valid low
        held = {result, c_out, x_out, v_out, n_out, z_out};
        @(negedge clk);
        operand = 32'h1357_9BDF; shift_cnt = 8'd7;
        @(negedge clk);
        check("R2", {result, c_out, x_out, v_out, n_out, z_out}, held);
        checks++;
        if (out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R2: out_valid got %b expected 0", out_valid);
        end

        // constrained random
        for (int k = 0; k < 600; k++) begin
            logic [2:0] op = 3'($urandom_range(7));
            logic [1:0] sz = 2'($urandom_range(3));
            logic [7:0] cn = ($urandom_range(3) == 0) ? 8'($urandom_range(40)) : 8'($urandom);
            logic [31:0] a = $urandom;
            if ($urandom_range(7) == 0) a = 32'h8000_0000 >> $urandom_range(31);
            run(op, sz, cn, a, 1'($urandom), tag_of(op));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule